// File: doc/BRIEF.md
# Device-to-Host Stream Buffer Controller

This block sits between a word stream produced by user logic and a ring of fixed-size buffers in host memory. Each accepted word goes out at once as a DMA write request, addressed to the current buffer at the current byte offset. A buffer is handed to the host with a release message once it fills. It is also handed over when the host asks for a flush, and that message carries the true byte count. A released buffer remains the host's property until the host returns it through a free command. Buffers are used and returned in strict round-robin order.

A separate nonempty notice can be enabled. It tells the host that the channel has gone from holding no unsubmitted data to holding some, so the host can wake a poller without waiting for a full buffer. In synchronous mode the block moves only as many bytes as the host has granted. The word width can be 8, 16 or 32 bits. The buffer count and the buffer size are powers of two, so a DMA address is the base plus the concatenation of buffer index and byte offset.

Top module: `d2h_stream_buf`

## Requirements
- R1: After reset no message and no DMA write is pending, input is ready, and the first word is written to BASE_ADDR.
- R2: Each accepted word produces one DMA write in the same cycle, at address BASE_ADDR + index*BUF_BYTES + offset, where the offset grows by WORD_BITS/8 per word.
- R3: When a word fills the current buffer, a release message is produced with msg_kind=0, msg_buf_idx equal to that buffer's index and msg_bytes=BUF_BYTES, and the next word goes to index+1 (mod NUM_BUFS) at offset 0.
- R4: A partly filled buffer produces no release message while no flush is requested.
- R5: A flush command with a nonzero fill produces a release message carrying the true byte count, and the next word goes to the following buffer at offset 0.
- R6: A flush command that finds zero bytes in the current buffer, including one given in the cycle that the last word of a buffer is accepted, produces no message.
- R7: While every buffer has been released and none freed, in_ready is low. A free command, whose index must be the oldest released buffer, makes input ready again.
- R8: With NONEMPTY_EN=1, a word accepted into an empty buffer produces a message with msg_kind=1, msg_buf_idx of that buffer and msg_bytes=0, delivered ahead of any release message pending at the same time.
- R9: With NONEMPTY_EN=0, no msg_kind=1 message is ever produced.
- R10: With SYNC_MODE=1, input is not ready while fewer than WORD_BITS/8 granted bytes remain, and the block accepts exactly the granted bytes.
- R11: A message that is offered while msg_ready is low stays valid and unchanged until it is taken.
- R12: While a release message waits for msg_ready, no word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream word offered |
| in_data | input | WORD_BITS | Stream word |
| in_ready | output | 1 | Block accepts the word this cycle |
| wr_valid | output | 1 | DMA write request |
| wr_ready | input | 1 | DMA path can take a write |
| wr_addr | output | ADDR_W | DMA byte address |
| wr_data | output | WORD_BITS | DMA write data |
| msg_valid | output | 1 | Message offered to the message queue |
| msg_ready | input | 1 | Message queue takes the message |
| msg_kind | output | 1 | 0 release, 1 nonempty |
| msg_buf_idx | output | IDX_W | Buffer index carried by the message |
| msg_bytes | output | CNT_W | Byte count of a released buffer |
| host_free_valid | input | 1 | Host returns a buffer |
| host_free_idx | input | IDX_W | Index of the returned buffer |
| host_flush | input | 1 | Host asks for the partial buffer |
| host_grant_valid | input | 1 | Host adds a byte grant (synchronous mode) |
| host_grant_bytes | input | GNT_W | Bytes added to the grant |

## Verification
Two cases can land in the same cycle. In one, a host flush arrives in the cycle that the last word of a buffer is accepted. In the other, a release message and a nonempty notice both become pending when a word empties the wait state. The bench provokes the first by raising host_flush alongside the final word of a buffer. It then requires exactly one full-size release, no extra zero-length message, and the next word at offset 0 of the following buffer. It provokes the second by holding msg_ready low across a whole buffer's worth of words. It requires the nonempty notice first, the release second, both held steady, and input stalled while the release waits.

// File: rtl/d2h_stream_buf.sv
module d2h_stream_buf #(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_BYTES = 16,
  parameter int WORD_BITS = 32,
  parameter int ADDR_W    = 32,
  parameter int GNT_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1000_0000,
  parameter bit SYNC_MODE   = 1'b0,
  parameter bit NONEMPTY_EN = 1'b1,
  localparam int IDX_W  = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int OFS_W  = $clog2(BUF_BYTES),
  localparam int CNT_W  = OFS_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WORD_BITS-1:0] in_data,
  output logic                 in_ready,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [WORD_BITS-1:0] wr_data,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic                 msg_kind,
  output logic [IDX_W-1:0]     msg_buf_idx,
  output logic [CNT_W-1:0]     msg_bytes,
  input  logic                 host_free_valid,
  input  logic [IDX_W-1:0]     host_free_idx,
  input  logic                 host_flush,
  input  logic                 host_grant_valid,
  input  logic [GNT_W-1:0]     host_grant_bytes
);
  localparam int WB     = WORD_BITS / 8;
  localparam int FREE_W = $clog2(NUM_BUFS + 1);

  logic [IDX_W-1:0]  cur_idx, old_idx, rel_idx, ne_idx;
  logic [CNT_W-1:0]  fill, rel_bytes;
  logic [FREE_W-1:0] free_cnt;
  logic [GNT_W-1:0]  grant_left;
  logic              rel_pend, ne_pend, flush_pend;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(NUM_BUFS - 1)) ? '0 : i + 1'b1;
  endfunction

  wire gnt_ok = !SYNC_MODE || (grant_left >= GNT_W'(WB));
  assign in_ready = (free_cnt != '0) && !rel_pend && !flush_pend && wr_ready && gnt_ok;

  wire             take      = in_valid && in_ready;
  wire [CNT_W-1:0] fill_nx   = fill + CNT_W'(WB);
  wire             full_now  = take && (fill_nx == CNT_W'(BUF_BYTES));
  wire             flush_go  = flush_pend && !rel_pend;
  wire             flush_sub = flush_go && (fill != '0);
  wire             submit    = full_now || flush_sub;

  assign wr_valid = take;
  assign wr_data  = in_data;
  assign wr_addr  = BASE_ADDR + ADDR_W'({cur_idx, fill[OFS_W-1:0]});

  assign msg_valid   = ne_pend || rel_pend;
  assign msg_kind    = ne_pend;
  assign msg_buf_idx = ne_pend ? ne_idx : rel_idx;
  assign msg_bytes   = ne_pend ? '0 : rel_bytes;

  wire msg_fire = msg_valid && msg_ready;
  wire ne_done  = msg_fire && ne_pend;
  wire rel_done = msg_fire && !ne_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx    <= '0;
      old_idx    <= '0;
      rel_idx    <= '0;
      ne_idx     <= '0;
      fill       <= '0;
      rel_bytes  <= '0;
      free_cnt   <= FREE_W'(NUM_BUFS);
      grant_left <= '0;
      rel_pend   <= 1'b0;
      ne_pend    <= 1'b0;
      flush_pend <= 1'b0;
    end else begin
      if (take) fill <= full_now ? '0 : fill_nx;
      else if (flush_sub) fill <= '0;

      if (submit) begin
        cur_idx   <= next_idx(cur_idx);
        rel_idx   <= cur_idx;
        rel_bytes <= full_now ? CNT_W'(BUF_BYTES) : fill;
        rel_pend  <= 1'b1;
      end else if (rel_done) begin
        rel_pend  <= 1'b0;
      end

      if (NONEMPTY_EN && take && fill == '0) begin
        ne_pend <= 1'b1;
        ne_idx  <= cur_idx;
      end else if (ne_done) begin
        ne_pend <= 1'b0;
      end

      if (host_flush) flush_pend <= 1'b1;
      else if (flush_go) flush_pend <= 1'b0;

      case ({submit, host_free_valid})
        2'b10:   free_cnt <= free_cnt - 1'b1;
        2'b01:   free_cnt <= free_cnt + 1'b1;
        default: ;
      endcase
      if (host_free_valid) old_idx <= next_idx(old_idx);

      if (SYNC_MODE)
        grant_left <= grant_left + (host_grant_valid ? host_grant_bytes : '0)
                                 - (take ? GNT_W'(WB) : '0);
    end
  end

  assert_free_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_free_valid |-> (host_free_idx == old_idx) && (free_cnt < FREE_W'(NUM_BUFS)));

  assert_no_input_when_all_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> !wr_valid);

  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_kind)
                                  && $stable(msg_buf_idx) && $stable(msg_bytes));

  assert_release_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_kind) |-> (msg_bytes != '0) && (msg_bytes <= CNT_W'(BUF_BYTES)));

  assert_no_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !NONEMPTY_EN |-> !(msg_valid && msg_kind));

  assert_stall_on_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_kind) |-> !wr_valid);

  assert_full_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_now |=> (fill == '0) && rel_pend);
endmodule

// File: tb/d2h_stream_buf_bench.sv
`timescale 1ns/100ps
module d2h_stream_buf_bench;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, wr_ready = 1, msg_ready = 1, host_free_valid = 0, host_flush = 0;
  logic host_grant_valid = 0;
  logic [1:0] host_free_idx = '0;
  logic [15:0] host_grant_bytes = '0;
  logic [31:0] in_data = '0, wr_addr, wr_data;
  logic in_ready, wr_valid, msg_valid, msg_kind;
  logic [1:0] msg_buf_idx;
  logic [4:0] msg_bytes;

  d2h_stream_buf u_d2h_stream_buf (
    .clk, .rst_n, .in_valid, .in_data, .in_ready, .wr_valid, .wr_ready, .wr_addr,
    .wr_data, .msg_valid, .msg_ready, .msg_kind, .msg_buf_idx, .msg_bytes,
    .host_free_valid, .host_free_idx, .host_flush, .host_grant_valid, .host_grant_bytes);

  logic s_in_valid = 0, s_grant_valid = 0;
  logic [15:0] s_grant_bytes = '0, s_in_data = 16'hbeef, s_wr_data;
  logic s_in_ready, s_wr_valid, s_msg_valid, s_msg_kind;
  logic [31:0] s_wr_addr;
  logic [1:0] s_msg_idx;
  logic [4:0] s_msg_bytes;

  d2h_stream_buf #(.WORD_BITS(16), .SYNC_MODE(1'b1), .NONEMPTY_EN(1'b0)) u_d2h_stream_buf_sync (
    .clk, .rst_n, .in_valid(s_in_valid), .in_data(s_in_data), .in_ready(s_in_ready),
    .wr_valid(s_wr_valid), .wr_ready(1'b1), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
    .msg_valid(s_msg_valid), .msg_ready(1'b1), .msg_kind(s_msg_kind), .msg_buf_idx(s_msg_idx),
    .msg_bytes(s_msg_bytes), .host_free_valid(1'b0), .host_free_idx(2'd0), .host_flush(1'b0),
    .host_grant_valid(s_grant_valid), .host_grant_bytes(s_grant_bytes));

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_addr[$];
  logic [7:0]  exp_msg[$];
  int m_idx = 0, m_fill = 0;
  int s_acc = 0, s_ne = 0, s_rel = 0;
  logic [7:0] s_last_rel = '0;
  logic hold_flag = 0;
  logic [7:0] hold_val = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: samples 1 ns before each rising edge
  always begin
    @(negedge clk); #1.5;
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_addr.size() == 0) check(0, "R2 unexpected write", wr_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_addr.pop_front();
          check(wr_addr == e, "R2 address", wr_addr, e);
        end
      end
      if (hold_flag)
        check(msg_valid && {msg_kind, msg_buf_idx, msg_bytes} == hold_val, "R11 hold",
              {msg_valid, msg_kind, msg_buf_idx, msg_bytes}, {1'b1, hold_val});
      hold_flag = msg_valid && !msg_ready;
      hold_val  = {msg_kind, msg_buf_idx, msg_bytes};
      if (msg_valid && msg_ready) begin
        if (exp_msg.size() == 0) check(0, "R4 unexpected message", {msg_kind, msg_buf_idx, msg_bytes}, 0);
        else begin
          logic [7:0] e;
          e = exp_msg.pop_front();
          check({msg_kind, msg_buf_idx, msg_bytes} == e, "R3 R5 R8 message",
                {msg_kind, msg_buf_idx, msg_bytes}, e);
        end
      end
      if (s_wr_valid) s_acc++;
      if (s_msg_valid) begin
        if (s_msg_kind) s_ne++;
        else begin s_rel++; s_last_rel = {s_msg_kind, s_msg_idx, s_msg_bytes}; end
      end
    end
  end

  task automatic model_word();
    if (m_fill == 0) exp_msg.push_back({1'b1, 2'(m_idx), 5'd0});
    exp_addr.push_back(BASE + 32'(m_idx * 16 + m_fill));
    m_fill += 4;
    if (m_fill == 16) begin
      exp_msg.push_back({1'b0, 2'(m_idx), 5'd16});
      m_idx = (m_idx + 1) % 4;
      m_fill = 0;
    end
  endtask

  task automatic push_word(input logic [31:0] d, input bit with_flush);
    in_valid = 1; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    model_word();
    if (with_flush) host_flush = 1;
    @(negedge clk);
    in_valid = 0; host_flush = 0;
  endtask

  task automatic flush();
    host_flush = 1;
    if (m_fill != 0) begin
      exp_msg.push_back({1'b0, 2'(m_idx), 5'(m_fill)});
      m_idx = (m_idx + 1) % 4;
      m_fill = 0;
    end
    @(negedge clk); host_flush = 0;
  endtask

  task automatic free_buf(input int i);
    host_free_valid = 1; host_free_idx = 2'(i);
    @(negedge clk); host_free_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(4); rst_n = 1; #1;
    check(!msg_valid && !wr_valid && in_ready, "R1 reset state",
          {msg_valid, wr_valid, in_ready}, 3'b001);
    check(!s_msg_valid && !s_in_ready, "R10 no grant after reset", {s_msg_valid, s_in_ready}, 0);
    @(negedge clk);

    for (int i = 0; i < 4; i++) push_word(32'h100 + i, 0);       // R2 R3 R8
    idle(4);
    for (int i = 0; i < 3; i++) push_word(32'h200 + i, 0);
    idle(10); #1;
    check(!msg_valid && exp_msg.size() == 0, "R4 no partial release", msg_valid, 0);
    @(negedge clk);
    flush(); idle(4);                                               // R5 count 12, idx1
    push_word(32'h300, 0); idle(3);                                 // idx2 offset 0
    flush(); idle(3);                                               // R5 count 4
    flush(); idle(6); #1;
    check(!msg_valid && exp_msg.size() == 0, "R6 empty flush silent", msg_valid, 0);
    @(negedge clk);

    for (int i = 0; i < 4; i++) push_word(32'h400 + i, 0);        // fills idx3
    idle(4); #1;
    check(!in_ready, "R7 stall with all buffers released", in_ready, 0);
    @(negedge clk);
    free_buf(0); #1;
    check(in_ready, "R7 ready after free", in_ready, 1);
    @(negedge clk);
    free_buf(1); free_buf(2); free_buf(3);

    msg_ready = 0;
    for (int i = 0; i < 4; i++) push_word(32'h500 + i, 0);        // idx0, R8 ordering
    idle(3); #1;
    check(!in_ready && msg_valid && msg_kind, "R12 stall while message waits",
          {in_ready, msg_valid, msg_kind}, 3'b011);
    @(negedge clk);
    msg_ready = 1; idle(4);
    free_buf(0);

    for (int i = 0; i < 3; i++) push_word(32'h600 + i, 0);        // idx1
    push_word(32'h603, 1);                                         // flush with last word
    idle(8); #1;
    check(!msg_valid && exp_msg.size() == 0, "R6 coincident flush silent", exp_msg.size(), 0);
    @(negedge clk);
    push_word(32'h700, 0); idle(4);                                // idx2 offset 0
    check(exp_addr.size() == 0, "R2 all writes seen", exp_addr.size(), 0);

    s_in_valid = 1; idle(5);
    check(s_acc == 0, "R10 nothing moves without grant", s_acc, 0);
    s_grant_valid = 1; s_grant_bytes = 16'd4;
    @(negedge clk); s_grant_valid = 0;
    idle(6);
    check(s_acc == 2, "R10 accepts granted bytes only", s_acc, 2);
    s_grant_valid = 1; s_grant_bytes = 16'd12;
    @(negedge clk); s_grant_valid = 0;
    idle(12);
    check(s_acc == 8, "R10 second grant", s_acc, 8);
    check(s_rel == 1 && s_last_rel == {1'b0, 2'd0, 5'd16}, "R3 sync release",
          s_last_rel, {1'b0, 2'd0, 5'd16});
    check(s_ne == 0, "R9 nonempty disabled", s_ne, 0);
    s_in_valid = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule